// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

This block runs the transmit side of a packet interface from a ring of descriptors kept in shared memory. Software programs a ring base address, fills descriptors (each one a control word followed by a buffer address word), and then sets a start bit. The engine reads each descriptor in turn and offers the buffer address and byte count to a frame-transmit stub. When the stub reports completion, the engine writes the completion status back into the control word and drops the ownership bit. It then moves to the next slot, or back to the base when the slot carries a wrap marker.

The engine stops as soon as it reads a descriptor that software has not handed over, and it clears its own start bit when it does. Two sticky status flags (frame done, frame error) drive an interrupt line through a mask bit. Fragment chaining is supported: a descriptor with the chain bit set tells the stub that the frame continues in the next buffer.

The sequencer has five states. S_IDLE moves to S_GET_CTL while the start bit is set. S_GET_CTL reads the control word; on the memory acknowledge it moves to S_GET_BUF if the ownership bit is set, and otherwise stops (back to S_IDLE, start bit cleared). S_GET_BUF reads the address word and moves to S_SEND on acknowledge. S_SEND holds the stub request and moves to S_PUT_CTL when the stub reports done. S_PUT_CTL writes the control word back, advances the slot index, and returns to S_IDLE on acknowledge.

Top module: `txd_ring_engine`

## Requirements
- R1: After reset the control, status and base registers read as zero, `irq` is low, and neither `mem_req` nor `xmit_req` is asserted.
- R2: Register map (`reg_addr`): 0 is control, 1 is status, 2 is base. Descriptor slot i is read at base + 8*i: the control word first, then the buffer address word at base + 8*i + 4. The stub receives that address on `xmit_addr` and the control word bits 10:0 on `xmit_len`. Both are held stable until `xmit_done`.
- R3: Control bit 11 is ownership. If a fetched control word has bit 11 clear, no stub request is made, the engine goes idle, and control register bit 0 (start) reads 0.
- R4: After `xmit_done`, the control word is written back with bit 11 cleared and `xmit_stat` placed in bits 16:14 (bit 14 underrun, bit 15 retry-limit abort, bit 16 late collision). All other bits are preserved.
- R5: Control bit 12 (wrap) makes the next descriptor come from slot 0. Without it, the next slot is the current slot + 1, modulo 128.
- R6: Control bit 17 (chain) marks a fragment that continues; `xmit_last` is the inverse of bit 17.
- R7: Status bit 0 (done) is set when a descriptor whose control bit 13 (interrupt request) is set completes; it is not set for descriptors without bit 13.
- R8: Status bit 1 (error) is set when a descriptor completes with a non-zero `xmit_stat`, whether or not bit 13 is set.
- R9: Writing a 1 to a status bit clears it; writing 0 leaves it.
- R10: `irq` is high exactly when control bit 1 (interrupt enable) is set and status bit 0 or bit 1 is set.
- R11: The base register keeps bits 31:10 and reads zeros in bits 9:0 (the ring table is 1024 bytes).
- R12: Setting the start bit again resumes at the slot where the engine stopped, not at the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational on reg_addr) |
| mem_req | output | 1 | Descriptor memory request, held until mem_ack |
| mem_we | output | 1 | 1 for a write-back, 0 for a read |
| mem_addr | output | 32 | Descriptor word byte address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge, one cycle |
| xmit_req | output | 1 | Buffer offered to the transmit stub |
| xmit_addr | output | 32 | Buffer address |
| xmit_len | output | 11 | Buffer length in bytes |
| xmit_last | output | 1 | Buffer ends the frame |
| xmit_done | input | 1 | Stub finished the buffer, one cycle |
| xmit_stat | input | 3 | Completion status from the stub |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check several rules on every cycle. A stub request stays stable until it is accepted. A write-back never leaves the ownership bit set. A descriptor the engine does not own never produces a request. A wrap sends the index to slot 0. A one written to the done bit clears it, and the stop path clears the start bit. Other behaviour can only be shown by the bench scenarios. These include whether the status lands in the right bits of the right memory word, and whether the order of buffers offered across chaining, wrap and resume matches the ring. Two rules need whole scenarios: done is raised only for descriptors that request it, while the error flag is raised regardless. The bench places decoy descriptors that would be sent if the wrap were ignored, so a wrong slot sequence shows up as an unexpected item in the scoreboard.

// File: rtl/txd_pkg.sv
package txd_pkg;
    localparam int unsigned DEF_NUM_DESC = 128;
    localparam int unsigned LEN_W        = 11;

    // control/status word bit positions
    localparam int unsigned OWN_BIT  = 11;
    localparam int unsigned WRAP_BIT = 12;
    localparam int unsigned IRQ_BIT  = 13;
    localparam int unsigned STAT_LSB = 14;
    localparam int unsigned STAT_W   = 3;
    localparam int unsigned CHAIN_BIT = 17;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_BASE = 2'd2;

    typedef enum logic [2:0] {
        S_IDLE,
        S_GET_CTL,
        S_GET_BUF,
        S_SEND,
        S_PUT_CTL
    } seq_state_e;
endpackage

// File: rtl/txd_regs.sv
module txd_regs
    import txd_pkg::*;
#(
    parameter int unsigned OFS_W = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata,
    input  logic        set_done,
    input  logic        set_err,
    input  logic        clr_txen,
    output logic        tx_en,
    output logic        base_wr,
    output logic [31:0] base,
    output logic        irq
);
    logic                tx_en_q, irq_en_q, done_q, err_q;
    logic [31:OFS_W]     base_q;
    logic                wr_ctrl, wr_stat;
    logic                unused_wbits;

    assign wr_ctrl = wr && (addr == RA_CTRL);
    assign wr_stat = wr && (addr == RA_STAT);
    assign base_wr = wr && (addr == RA_BASE);
    assign unused_wbits = ^{wdata[OFS_W-1:2]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_q  <= 1'b0;
            irq_en_q <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            base_q   <= '0;
        end else begin
            if (wr_ctrl) begin
                tx_en_q  <= wdata[0];
                irq_en_q <= wdata[1];
            end else if (clr_txen) begin
                tx_en_q <= 1'b0;
            end
            done_q <= set_done | (done_q & ~(wr_stat & wdata[0]));
            err_q  <= set_err  | (err_q  & ~(wr_stat & wdata[1]));
            if (base_wr) base_q <= wdata[31:OFS_W];
        end
    end

    always_comb begin
        unique case (addr)
            RA_CTRL: rdata = {30'd0, irq_en_q, tx_en_q};
            RA_STAT: rdata = {30'd0, err_q, done_q};
            RA_BASE: rdata = {base_q, {OFS_W{1'b0}}};
            default: rdata = 32'd0;
        endcase
    end

    assign tx_en = tx_en_q;
    assign base  = {base_q, {OFS_W{1'b0}}};
    assign irq   = irq_en_q & (done_q | err_q);

    // R9: a one written to the done bit clears it unless a new completion arrives
    p_w1c_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stat && wdata[0] && !set_done) |=> !done_q);

    // R3: the stop path drops the start bit when software is not writing control
    p_stop_clears_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_txen && !wr_ctrl) |=> !tx_en_q);
endmodule

// File: rtl/txd_seq.sv
module txd_seq
    import txd_pkg::*;
#(
    parameter int unsigned NUM_DESC = DEF_NUM_DESC
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tx_en,
    input  logic             base_wr,
    input  logic [31:0]      base,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic [31:0]      mem_rdata,
    input  logic             mem_ack,
    output logic             xmit_req,
    output logic [31:0]      xmit_addr,
    output logic [LEN_W-1:0] xmit_len,
    output logic             xmit_last,
    input  logic             xmit_done,
    input  logic [STAT_W-1:0] xmit_stat,
    output logic             clr_txen,
    output logic             set_done,
    output logic             set_err
);
    localparam int unsigned IDX_W = $clog2(NUM_DESC);
    localparam int unsigned OFS_W = IDX_W + 3;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

    seq_state_e          state_q, state_d;
    logic [IDX_W-1:0]    idx_q;
    logic [31:0]         ctl_q, buf_q;
    logic [STAT_W-1:0]   stat_q;
    logic                word_sel;
    logic [31:0]         wb_word;
    logic                unused_base;

    assign unused_base = ^{base[OFS_W-1:0]};

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (tx_en) state_d = S_GET_CTL;
            S_GET_CTL: if (mem_ack) state_d = mem_rdata[OWN_BIT] ? S_GET_BUF : S_IDLE;
            S_GET_BUF: if (mem_ack) state_d = S_SEND;
            S_SEND:    if (xmit_done) state_d = S_PUT_CTL;
            S_PUT_CTL: if (mem_ack) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // write-back word: ownership dropped, stub status inserted
    always_comb begin
        wb_word = ctl_q;
        wb_word[OWN_BIT] = 1'b0;
        wb_word[STAT_LSB +: STAT_W] = stat_q;
    end

    // outputs
    always_comb begin
        mem_req   = (state_q == S_GET_CTL) || (state_q == S_GET_BUF) || (state_q == S_PUT_CTL);
        mem_we    = (state_q == S_PUT_CTL);
        word_sel  = (state_q == S_GET_BUF);
        mem_addr  = {base[31:OFS_W], idx_q, word_sel, 2'b00};
        mem_wdata = wb_word;
        xmit_req  = (state_q == S_SEND);
        xmit_addr = buf_q;
        xmit_len  = ctl_q[LEN_W-1:0];
        xmit_last = ~ctl_q[CHAIN_BIT];
        clr_txen  = (state_q == S_GET_CTL) && mem_ack && !mem_rdata[OWN_BIT];
        set_done  = (state_q == S_PUT_CTL) && mem_ack && ctl_q[IRQ_BIT];
        set_err   = (state_q == S_PUT_CTL) && mem_ack && (stat_q != '0);
    end

    // datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            ctl_q  <= '0;
            buf_q  <= '0;
            stat_q <= '0;
        end else begin
            if (state_q == S_GET_CTL && mem_ack) ctl_q <= mem_rdata;
            if (state_q == S_GET_BUF && mem_ack) buf_q <= mem_rdata;
            if (state_q == S_SEND && xmit_done) stat_q <= xmit_stat;
            if (base_wr) begin
                idx_q <= '0;
            end else if (state_q == S_PUT_CTL && mem_ack) begin
                if (ctl_q[WRAP_BIT] || idx_q == LAST_IDX) idx_q <= '0;
                else                                      idx_q <= idx_q + 1'b1;
            end
        end
    end

    // R2: the offer to the stub is held stable until it is taken
    p_hold_offer_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xmit_req && !xmit_done) |=> (xmit_req && $stable(xmit_addr) && $stable(xmit_len)));

    // R4: a write-back never hands the descriptor back to hardware
    p_wb_drops_own_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> !mem_wdata[OWN_BIT]);

    // R3: a descriptor not owned by hardware leads to no request of any kind
    p_unowned_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_GET_CTL && mem_ack && !mem_rdata[OWN_BIT]) |=> (!xmit_req && !mem_req));

    // R5: a wrap marker sends the index home
    p_wrap_home_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PUT_CTL && mem_ack && ctl_q[WRAP_BIT]) |=> (idx_q == '0));
endmodule

// File: rtl/txd_ring_engine.sv
module txd_ring_engine
    import txd_pkg::*;
#(
    parameter int unsigned NUM_DESC = DEF_NUM_DESC
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic [31:0] mem_rdata,
    input  logic        mem_ack,
    output logic        xmit_req,
    output logic [31:0] xmit_addr,
    output logic [10:0] xmit_len,
    output logic        xmit_last,
    input  logic        xmit_done,
    input  logic [2:0]  xmit_stat,
    output logic        irq
);
    localparam int unsigned OFS_W = $clog2(NUM_DESC) + 3;

    logic        tx_en, base_wr, clr_txen, set_done, set_err;
    logic [31:0] base;

    txd_regs #(.OFS_W(OFS_W)) regs_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .set_done (set_done),
        .set_err  (set_err),
        .clr_txen (clr_txen),
        .tx_en    (tx_en),
        .base_wr  (base_wr),
        .base     (base),
        .irq      (irq)
    );

    txd_seq #(.NUM_DESC(NUM_DESC)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_en     (tx_en),
        .base_wr   (base_wr),
        .base      (base),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .mem_ack   (mem_ack),
        .xmit_req  (xmit_req),
        .xmit_addr (xmit_addr),
        .xmit_len  (xmit_len),
        .xmit_last (xmit_last),
        .xmit_done (xmit_done),
        .xmit_stat (xmit_stat),
        .clr_txen  (clr_txen),
        .set_done  (set_done),
        .set_err   (set_err)
    );
endmodule

// File: tb/txd_ring_engine_tb_top.sv
`timescale 1ns/1ps
module txd_ring_engine_tb_top;
    localparam logic [31:0] BASE = 32'h8000_8000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = 32'd0;
    logic [31:0] reg_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 32'd0;
    logic        mem_ack = 1'b0;
    logic        xmit_req, xmit_last;
    logic [31:0] xmit_addr;
    logic [10:0] xmit_len;
    logic        xmit_done = 1'b0;
    logic [2:0]  xmit_stat = 3'd0;
    logic        irq;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] a;
        logic [10:0] l;
        logic        last;
        logic [2:0]  st;
    } item_t;
    item_t sbq[$];

    logic [31:0] tbmem [0:255];

    always #2.5 clk = ~clk;

    txd_ring_engine dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .xmit_req(xmit_req),
        .xmit_addr(xmit_addr), .xmit_len(xmit_len), .xmit_last(xmit_last),
        .xmit_done(xmit_done), .xmit_stat(xmit_stat), .irq(irq)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // memory responder: one-cycle acknowledge, driven away from the active edge
    always @(negedge clk) begin
        if (!rst_n || mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (mem_addr[31:10] != BASE[31:10])
                check(1'b0, "R2 ring address", mem_addr, BASE);
            if (mem_we) tbmem[mem_addr[9:2]] = mem_wdata;
            else        mem_rdata = tbmem[mem_addr[9:2]];
            mem_ack = 1'b1;
        end
    end

    // monitor + stub: pops expected offers and completes them
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && xmit_req) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R5 unexpected buffer offered", xmit_addr, 32'd0);
                    xmit_stat = 3'd0;
                end else begin
                    item_t e;
                    e = sbq.pop_front();
                    check(xmit_addr == e.a, "R2 buffer address", xmit_addr, e.a);
                    check(xmit_len == e.l, "R2 buffer length", {21'd0, xmit_len}, {21'd0, e.l});
                    check(xmit_last == e.last, "R6 last flag", {31'd0, xmit_last}, {31'd0, e.last});
                    xmit_stat = e.st;
                end
                repeat (2) @(negedge clk);
                xmit_done = 1'b1;
                @(negedge clk);
                xmit_done = 1'b0;
            end
        end
    end

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #0.5 d = reg_rdata;
    endtask

    // driver: places a descriptor and, when expected to be sent, queues it
    task automatic put_desc(input int slot, input logic [10:0] len, input logic [31:0] addr,
                            input bit wrap, input bit ie, input bit chain,
                            input logic [2:0] st, input bit expect_send);
        item_t e;
        tbmem[2*slot]   = {14'd0, chain, 3'd0, ie, wrap, 1'b1, len};
        tbmem[2*slot+1] = addr;
        if (expect_send) begin
            e.a = addr; e.l = len; e.last = !chain; e.st = st;
            sbq.push_back(e);
        end
    endtask

    function automatic logic [31:0] wb_expect(input logic [31:0] c, input logic [2:0] st);
        logic [31:0] r;
        r = c;
        r[11] = 1'b0;
        r[16:14] = st;
        return r;
    endfunction

    task automatic run_ring(input logic [31:0] ctrl_val);
        logic [31:0] d;
        int n = 0;
        reg_write(2'd0, ctrl_val);
        d = 32'd1;
        while (d[0] && n < 3000) begin
            reg_read(2'd0, d);
            n++;
        end
        check(d[0] == 1'b0, "R3 start bit cleared on stop", d, 32'd0);
        check(sbq.size() == 0, "R3 all queued buffers offered", sbq.size(), 32'd0);
        repeat (2) @(negedge clk);
        check(!xmit_req && !mem_req, "R3 engine idle after stop", {30'd0, xmit_req, mem_req}, 32'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        check(1'b0, "watchdog expired", 32'd0, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [31:0] c0, c1, c3;
        for (int i = 0; i < 256; i++) tbmem[i] = 32'd0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        reg_read(2'd0, d); check(d == 0, "R1 control reset", d, 0);
        reg_read(2'd1, d); check(d == 0, "R1 status reset", d, 0);
        reg_read(2'd2, d); check(d == 0, "R1 base reset", d, 0);
        check(!irq && !mem_req && !xmit_req, "R1 outputs idle", {29'd0, irq, mem_req, xmit_req}, 0);

        // R11: base alignment
        reg_write(2'd2, BASE | 32'h3FF);
        reg_read(2'd2, d); check(d == BASE, "R11 base low bits zero", d, BASE);

        // scenario A: two plain descriptors, third not owned
        put_desc(0, 11'd60,   32'h0000_1000, 0, 1, 0, 3'd0, 1);
        put_desc(1, 11'd1514, 32'h0000_2004, 0, 1, 0, 3'd0, 1);
        c0 = tbmem[0]; c1 = tbmem[2];
        run_ring(32'h1);
        check(tbmem[0] == wb_expect(c0, 3'd0), "R4 write-back slot 0", tbmem[0], wb_expect(c0, 3'd0));
        check(tbmem[2] == wb_expect(c1, 3'd0), "R4 write-back slot 1", tbmem[2], wb_expect(c1, 3'd0));
        reg_read(2'd1, d); check(d == 32'h1, "R7 done set, R8 no error", d, 32'h1);
        check(!irq, "R10 irq masked", {31'd0, irq}, 0);
        reg_write(2'd1, 32'h0);
        reg_read(2'd1, d); check(d == 32'h1, "R9 zero write keeps flag", d, 32'h1);
        reg_write(2'd1, 32'h1);
        reg_read(2'd1, d); check(d == 32'h0, "R9 one clears done", d, 0);

        // scenario B: resume at slot 2, chained frame, wrap at slot 3, decoy at slot 4
        put_desc(2, 11'd100, 32'h0000_3000, 0, 0, 1, 3'd0, 1);
        put_desc(3, 11'd40,  32'h0000_3100, 1, 1, 0, 3'd1, 1);
        put_desc(4, 11'd77,  32'h0000_DEC0, 0, 0, 0, 3'd0, 0);
        c3 = tbmem[6];
        run_ring(32'h1);   // R12 resume point, R5 wrap to slot 0 (not owned)
        check(tbmem[6] == wb_expect(c3, 3'd1), "R4 status bits in write-back", tbmem[6], wb_expect(c3, 3'd1));
        check(tbmem[8][11] == 1'b1, "R5 slot after wrap untouched", tbmem[8], 32'h800);
        reg_read(2'd1, d); check(d == 32'h3, "R8 error and R7 done", d, 32'h3);
        check(!irq, "R10 irq low while masked", {31'd0, irq}, 0);
        reg_write(2'd0, 32'h2);
        #0.5 check(irq, "R10 irq with enable", {31'd0, irq}, 1);
        reg_write(2'd1, 32'h1);
        reg_read(2'd1, d); check(d == 32'h2, "R9 clear done only", d, 32'h2);
        check(irq, "R10 irq from error alone", {31'd0, irq}, 1);
        reg_write(2'd1, 32'h2);
        #0.5 check(!irq, "R10 irq drops when flags clear", {31'd0, irq}, 0);

        // scenario C: slot 0 wraps onto itself, no interrupt request, error status
        put_desc(0, 11'd8, 32'h0000_4000, 1, 0, 0, 3'd6, 1);
        put_desc(1, 11'd9, 32'h0000_DEC1, 0, 0, 0, 3'd0, 0);
        c0 = tbmem[0];
        run_ring(32'h3);
        check(tbmem[0] == wb_expect(c0, 3'd6), "R4 abort and late collision bits", tbmem[0], wb_expect(c0, 3'd6));
        reg_read(2'd1, d); check(d == 32'h2, "R7 no done without request, R8 error", d, 32'h2);
        check(irq, "R10 irq on error", {31'd0, irq}, 1);
        reg_read(2'd0, d); check(d == 32'h2, "R3 start cleared, irq enable kept", d, 32'h2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule